// File: doc/BRIEF.md
# Zeckendorf Fibonacci Digit Recoder

The block turns an unsigned binary scalar into its Zeckendorf form: a string of 0/1 digits, each weighting one Fibonacci number, such that the selected Fibonacci numbers are distinct, never neighbours, and sum to the scalar. Indexing follows F0=0, F1=1, F2=1, F3=2, F4=3, and so on. The lowest digit position is index 2. The string runs from a leading index down to index 2. A scalar recoded this way drives a Fibonacci-step point multiplication loop.

A strobe on `start` loads the input. The block first climbs the Fibonacci sequence until a term exceeds the input, which finds the leading index. It then walks back down, deriving each lower term from the two it holds. On every cycle of the descent it makes one greedy choice and emits one digit, most significant first. No table of Fibonacci numbers is stored. The internal registers are one bit wider than the input so that the first term past the input always fits.

A `done` pulse closes every recoding. An `err` flag beside it reports a non-zero remainder after the index-2 digit. Growing the input width by about 44% gives the number of digit positions, so a 160-bit input needs roughly 230.

Top module: `zeck_recoder`

## Requirements
- R1: After a non-zero start, digits appear on consecutive cycles with `dig_valid` high and no gap between them. The first digit has the leading index and each later digit has an index one lower. `dig_last` is high only on the digit for index 2.
- R2: No two consecutive emitted digits are both 1.
- R3: The sum of F(index) over all digits equal to 1 equals the input value. This is the greedy recoding, in which each 1 marks the largest Fibonacci number not exceeding the remainder. Input 17 gives digits 1,0,0,1,0,1 for indices 7 down to 2.
- R4: `lead_idx` holds the index of the largest Fibonacci number not exceeding the input. The first digit is 1, and the number of digits equals `lead_idx` minus 1.
- R5: `done` pulses high for exactly one cycle, on the cycle right after the `dig_last` digit, and `dig_valid` is low on that cycle.
- R6: An input of 0 produces no digits. It gives a `done` pulse on the cycle after `start` is sampled, with `lead_idx` equal to 0.
- R7: A `start` strobe while `busy` is high is ignored, and the digit stream of the running recoding is unchanged.
- R8: `err` is low on every `done` pulse for any input below 2^W.
- R9: After reset, `busy`, `dig_valid`, `dig_last`, `done` and `err` are low.
- R10: Two boundary inputs are handled. An input that is itself a Fibonacci number recodes to a single 1 followed by zeros. The all-ones input 2^W-1 recodes correctly, which for W=16 means a leading index of 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load `value` and begin recoding when idle |
| value | input | W | Unsigned scalar to recode |
| busy | output | 1 | A recoding is in progress |
| dig_valid | output | 1 | `dig_bit` carries a digit this cycle |
| dig_bit | output | 1 | Digit value: 1 selects F(index) |
| dig_last | output | 1 | This digit is the index-2 digit |
| lead_idx | output | $clog2(2W+4) | Leading Fibonacci index of the current or last input |
| done | output | 1 | One-cycle pulse ending a recoding |
| err | output | 1 | Non-zero remainder at end, valid with `done` |

## Verification
The bound checker watches several properties on every cycle. It checks that no two adjacent 1 digits appear and that the first digit of each stream is 1. It checks that `done` follows the last digit on the next cycle with no digit beside it, and that `done` never coincides with `busy`. It also checks that `err` is low at every `done` and that the digit count matches `lead_idx` at the last digit. Other behaviour is shown only by the bench scenarios, which compare against a greedy model: that the digits re-sum to the input, the exact digit pattern for 17, the leading index for Fibonacci and all-ones inputs, the zero-input shortcut, and the ignoring of a start strobe mid-stream.

// File: rtl/zeck_pkg.sv
package zeck_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GROW = 2'd1,
        ST_EMIT = 2'd2,
        ST_FIN  = 2'd3
    } zst_e;
endpackage

// File: rtl/zeck_fib_pair.sv
// Steps a pair of adjacent Fibonacci terms (lo = F(i), hi = F(i+1))
// one index up or one index down.
module zeck_fib_pair #(
    parameter int FW = 17
) (
    input  logic [FW-1:0] lo,
    input  logic [FW-1:0] hi,
    output logic [FW-1:0] up_lo,
    output logic [FW-1:0] up_hi,
    output logic [FW-1:0] dn_lo,
    output logic [FW-1:0] dn_hi
);
    always_comb begin
        up_lo = hi;
        up_hi = lo + hi;
        dn_lo = hi - lo;
        dn_hi = lo;
    end
endmodule

// File: rtl/zeck_greedy_cmp.sv
// One greedy decision: take the term if it fits in the remainder.
module zeck_greedy_cmp #(
    parameter int FW = 17
) (
    input  logic [FW-1:0] term,
    input  logic [FW-1:0] rem,
    output logic          take,
    output logic [FW-1:0] rem_next
);
    always_comb begin
        take     = (term <= rem);
        rem_next = take ? (rem - term) : rem;
    end
endmodule

// File: rtl/zeck_recoder.sv
module zeck_recoder #(
    parameter int W    = 16,
    localparam int FW   = W + 1,
    localparam int IDXW = $clog2(2 * W + 4)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [W-1:0]    value,
    output logic            busy,
    output logic            dig_valid,
    output logic            dig_bit,
    output logic            dig_last,
    output logic [IDXW-1:0] lead_idx,
    output logic            done,
    output logic            err
);
    import zeck_pkg::*;

    typedef struct packed {
        zst_e            st;
        logic [FW-1:0]   rem;
        logic [FW-1:0]   lo;
        logic [FW-1:0]   hi;
        logic [IDXW-1:0] idx;
        logic [IDXW-1:0] lead;
        logic            dval;
        logic            dbit;
        logic            dlast;
        logic            done;
        logic            err;
    } zreg_t;

    zreg_t r_d, r_q;

    logic [FW-1:0] up_lo, up_hi, dn_lo, dn_hi;
    logic          take;
    logic [FW-1:0] rem_next;

    zeck_fib_pair #(.FW(FW)) fib_i (
        .lo    (r_q.lo),
        .hi    (r_q.hi),
        .up_lo (up_lo),
        .up_hi (up_hi),
        .dn_lo (dn_lo),
        .dn_hi (dn_hi)
    );

    zeck_greedy_cmp #(.FW(FW)) cmp_i (
        .term     (r_q.lo),
        .rem      (r_q.rem),
        .take     (take),
        .rem_next (rem_next)
    );

    always_comb begin
        r_d       = r_q;
        r_d.dval  = 1'b0;
        r_d.dbit  = 1'b0;
        r_d.dlast = 1'b0;
        r_d.done  = 1'b0;
        r_d.err   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (value == '0) begin
                        r_d.done = 1'b1;
                        r_d.lead = '0;
                    end else begin
                        r_d.st  = ST_GROW;
                        r_d.rem = {1'b0, value};
                        r_d.lo  = FW'(1);
                        r_d.hi  = FW'(2);
                        r_d.idx = IDXW'(2);
                    end
                end
            end
            ST_GROW: begin
                if (r_q.hi > r_q.rem) begin
                    r_d.st   = ST_EMIT;
                    r_d.lead = r_q.idx;
                end else begin
                    r_d.lo  = up_lo;
                    r_d.hi  = up_hi;
                    r_d.idx = r_q.idx + IDXW'(1);
                end
            end
            ST_EMIT: begin
                r_d.dval = 1'b1;
                r_d.dbit = take;
                r_d.rem  = rem_next;
                if (r_q.idx == IDXW'(2)) begin
                    r_d.dlast = 1'b1;
                    r_d.st    = ST_FIN;
                end else begin
                    r_d.lo  = dn_lo;
                    r_d.hi  = dn_hi;
                    r_d.idx = r_q.idx - IDXW'(1);
                end
            end
            ST_FIN: begin
                r_d.done = 1'b1;
                r_d.err  = (r_q.rem != '0);
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign dig_valid = r_q.dval;
    assign dig_bit   = r_q.dbit;
    assign dig_last  = r_q.dlast;
    assign lead_idx  = r_q.lead;
    assign done      = r_q.done;
    assign err       = r_q.err;
endmodule

// File: rtl/zeck_recoder_chk.sv
module zeck_recoder_chk #(
    parameter int IDXW = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            dig_valid,
    input logic            dig_bit,
    input logic            dig_last,
    input logic [IDXW-1:0] lead_idx,
    input logic            done,
    input logic            err
);
    logic            seen_q;
    logic [IDXW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else if (done) begin
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else if (dig_valid) begin
            seen_q <= 1'b1;
            cnt_q  <= cnt_q + IDXW'(1);
        end
    end

    // R2
    a_r2_no_adjacent_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid && dig_bit) |=> !(dig_valid && dig_bit));

    // R4
    a_r4_first_digit_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid && !seen_q) |-> dig_bit);

    // R4
    a_r4_count_matches_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid && dig_last) |-> (32'(cnt_q) + 2 == 32'(lead_idx)));

    // R5
    a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid && dig_last) |=> (done && !dig_valid));

    // R5
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done || !busy);

    // R5
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !dig_valid));

    // R8
    a_r8_no_error: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !err);
endmodule

bind zeck_recoder zeck_recoder_chk #(.IDXW(IDXW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .dig_valid (dig_valid),
    .dig_bit   (dig_bit),
    .dig_last  (dig_last),
    .lead_idx  (lead_idx),
    .done      (done),
    .err       (err)
);

// File: tb/zeck_recoder_tb_top.sv
`timescale 1ns/1ps
module zeck_recoder_tb_top;
    localparam int W    = 16;
    localparam int IDXW = $clog2(2 * W + 4);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [W-1:0]    value = '0;
    logic            busy, dig_valid, dig_bit, dig_last, done, err;
    logic [IDXW-1:0] lead_idx;

    int checks = 0;
    int errors = 0;
    longint fib [0:63];

    always #4 clk = ~clk;

    zeck_recoder #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .value(value),
        .busy(busy), .dig_valid(dig_valid), .dig_bit(dig_bit),
        .dig_last(dig_last), .lead_idx(lead_idx), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one recoding of v; if inject, pulses start with another value mid-stream.
    task automatic run_value(input longint v, input bit inject, input string tag);
        int     lead_e;
        int     ndig;
        int     exp_d [0:63];
        longint r;
        longint sum;
        int     prev;
        int     got_ok;
        bit     fin;
        int     guard;
        // greedy model
        lead_e = 0;
        if (v > 0) begin
            for (int k = 2; k < 60; k++) if (fib[k] <= v) lead_e = k;
        end
        r = v;
        for (int k = 63; k >= 0; k--) exp_d[k] = 0;
        for (int k = lead_e; k >= 2; k--) begin
            if (fib[k] <= r) begin exp_d[k] = 1; r -= fib[k]; end
        end
        @(negedge clk);
        value = W'(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ndig = 0; sum = 0; prev = 0; got_ok = 1; fin = 0; guard = 0;
        while (!fin && guard < 400) begin
            if (dig_valid) begin
                int ix;
                ix = lead_e - ndig;
                if (ix < 2 || dig_bit !== 1'(exp_d[ix])) got_ok = 0;
                if (dig_bit) begin
                    if (ix >= 0) sum += fib[ix];
                    if (prev == 1) chk(0, {tag, " R2 adjacent ones"}, 1, 0);
                end
                if (ndig == 0) chk(dig_bit === 1'b1, {tag, " R4 first digit"}, dig_bit, 1);
                chk((dig_last === 1'b1) == (ix == 2), {tag, " R1 last flag"}, dig_last, ix == 2);
                prev = dig_bit;
                ndig++;
                if (inject && ndig == 1) begin
                    value = W'(5);
                    start = 1'b1;
                end else begin
                    start = 1'b0;
                end
                if (dig_last) begin
                    @(negedge clk);
                    start = 1'b0;
                    chk(done === 1'b1 && dig_valid === 1'b0, {tag, " R5 done after last"}, done, 1);
                    chk(err === 1'b0, {tag, " R8 err"}, err, 0);
                    fin = 1;
                end
            end else if (done) begin
                chk(ndig == 0 && v == 0, {tag, " R6 done without digits"}, ndig, 0);
                fin = 1;
            end else if (ndig > 0) begin
                chk(0, {tag, " R1 gap in digit stream"}, 0, 1);
            end
            if (!fin) begin
                @(negedge clk);
                start = 1'b0;
                guard++;
            end
        end
        start = 1'b0;
        chk(fin, {tag, " R1 stream completed"}, fin, 1);
        chk(got_ok == 1, {tag, " R3 digit pattern"}, got_ok, 1);
        chk(sum == v, {tag, " R3 re-summed value"}, sum, v);
        chk(int'(lead_idx) == lead_e, {tag, " R4 lead index"}, lead_idx, lead_e);
        if (v > 0) chk(ndig == lead_e - 1, {tag, " R4 digit count"}, ndig, lead_e - 1);
        @(negedge clk);
        chk(done === 1'b0, {tag, " R5 done single cycle"}, done, 0);
    endtask

    task automatic test_reset();
        chk(busy === 1'b0 && dig_valid === 1'b0 && dig_last === 1'b0, "R9 reset outputs", busy, 0);
        chk(done === 1'b0 && err === 1'b0, "R9 reset done/err", done, 0);
    endtask

    task automatic test_seventeen();
        run_value(17, 0, "R3_17");
        chk(int'(lead_idx) == 7, "R3 17 leading index 7", lead_idx, 7);
    endtask

    task automatic test_zero();
        @(negedge clk);
        value = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1 && dig_valid === 1'b0, "R6 zero done next cycle", done, 1);
        chk(lead_idx == '0, "R6 zero lead index", lead_idx, 0);
        chk(busy === 1'b0, "R6 zero not busy", busy, 0);
        @(negedge clk);
        chk(done === 1'b0 && dig_valid === 1'b0, "R6 zero no digits after", dig_valid, 0);
    endtask

    task automatic test_start_busy();
        run_value(17, 1, "R7_ignored_start");
        chk(busy === 1'b0, "R7 idle after run", busy, 0);
    endtask

    task automatic test_boundaries();
        run_value(46368, 0, "R10_fib24");
        run_value(65535, 0, "R10_all_ones");
        chk(int'(lead_idx) == 24, "R10 all-ones lead 24", lead_idx, 24);
        run_value(1, 0, "R10_one");
        run_value(2, 0, "R10_two");
    endtask

    task automatic test_patterns();
        run_value(4, 0, "R1_4");
        run_value(7, 0, "R1_7");
        run_value(100, 0, "R2_100");
        run_value(12345, 0, "R3_12345");
        run_value(54321, 0, "R3_54321");
        run_value(32767, 0, "R2_32767");
        run_value(40000, 0, "R3_40000");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        fib[0] = 0;
        fib[1] = 1;
        for (int k = 2; k < 64; k++) fib[k] = (k < 60) ? fib[k-1] + fib[k-2] : fib[59];
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_seventeen();
        test_zero();
        test_patterns();
        test_boundaries();
        test_start_busy();
        run_value(17, 0, "R7_back_to_back");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule